// File: doc/BRIEF.md
# Serial Management Frame Master (MDC/MDIO)

This block performs one register access on a two-wire serial management bus per request. When a start strobe is accepted it latches the access direction, a 5-bit device address, a 5-bit register address, the 16-bit write value and a phase length. It then produces the full frame on its own: a run of idle-level one bits to synchronise the far end, a short header, a turnaround, the data field and a final released bit. The clock line MDC is generated internally, and the data line is driven through a value output plus an output enable that an external tri-state pad combines.

Every bit period is split into four phases of equal length, during which MDC is low, high, high and low. The number of system clock cycles per phase is set with each request, so the bus rate follows from that value. During a read the data line is released and the incoming level is sampled at the end of the second phase, while MDC is high. When the frame ends the block raises a single-cycle done pulse, and a read result is presented from that same cycle.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `mdc_o` is 0, `mdio_oe_o` is 0 and `busy_o` is 0.
- R2: Each frame opens with 32 bit periods in which `mdio_oe_o` is 1 and `mdio_o` is 1.
- R3: The next 14 bit periods are driven MSB first: start code `01`, opcode (`10` when `rd_i`=1, `01` when `rd_i`=0), the 5-bit device address, then the 5-bit register address.
- R4: Each bit period lasts 4×L system cycles, where L is `phase_len_i` (a value of 0 acts as 1). MDC is low for the first L cycles, high for the next 2L and low for the last L. `mdio_o` and `mdio_oe_o` do not change within a bit period. A write frame has 65 bit periods and a read frame 64, so `done_o` rises 4×L×65 or 4×L×64 cycles after the edge that accepted the start.
- R5: On a write, the header is followed by two driven turnaround bits, 1 then 0, and then by the 16 write data bits, MSB first.
- R6: On a read, the header is followed by one bit period with `mdio_oe_o`=0 and then by 16 bit periods with `mdio_oe_o`=0. In each of those 16 bit periods `mdio_i` is sampled at the end of the second phase and shifted into the LSB, so the first bit received ends up as bit 15 of `rd_data_o`.
- R7: Both frame types end with one bit period in which `mdio_oe_o` is 0.
- R8: `busy_o` is 1 from the cycle after an accepted start. At the end of the last bit period `busy_o` falls and `done_o` is 1 for exactly one cycle. `rd_data_o` holds the read result from that cycle on, and a write frame leaves `rd_data_o` unchanged.
- R9: A start strobe that arrives while `busy_o` is 1 is ignored: the frame in progress keeps its content and its length.
- R10: The request inputs and `phase_len_i` are captured only when a start is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted only when idle |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| phy_addr_i | input | 5 | Device address on the bus |
| reg_addr_i | input | 5 | Register address inside the device |
| wdata_i | input | 16 | Value sent by a write |
| phase_len_i | input | 8 | System cycles per quarter bit period (0 acts as 1) |
| mdio_i | input | 1 | Level seen on the data line |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe_o | output | 1 | Output enable for the data line |
| rd_data_o | output | 16 | Result of the last read |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Reads and writes are issued with random device and register addresses, write values, read patterns and phase lengths, together with directed cases: a phase length of 0 against 1, all-ones and alternating data, a read pattern with only its end bits set, back-to-back frames of opposite direction, and start pulses plus changed inputs injected halfway through a frame. A bench-side device model returns its pattern one bit per falling clock edge, so a sampling point one phase early or late, or a turnaround length off by one, shows up as a shifted read word. Every observed bit period is compared against a frame built in the bench, which tells header order and opcode errors apart from turnaround and release errors. The total cycle count separates a wrong phase length from a wrong bit count.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

  // Frame segments, in transmit order.
  typedef enum logic [2:0] {
    SEG_PRE,
    SEG_HDR,
    SEG_TURN,
    SEG_DATA,
    SEG_TAIL
  } seg_e;

  // Quarter phases of one bit period: MDC low, high, high, low.
  typedef enum logic [1:0] {
    PH_LO0,
    PH_HI0,
    PH_HI1,
    PH_LO1
  } phase_e;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TURN_WR  = 2'b10;

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
  parameter int PHASE_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [PHASE_W-1:0] len_i,
  input  logic               run_i,
  output logic               tick_o
);

  logic [PHASE_W-1:0] len_q;
  logic [PHASE_W-1:0] cyc_q;

  // Last cycle of the current quarter phase.
  assign tick_o = run_i && (cyc_q == len_q - PHASE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= PHASE_W'(1);
      cyc_q <= '0;
    end else begin
      if (load_i) begin
        len_q <= (len_i == '0) ? PHASE_W'(1) : len_i;
      end
      if (load_i || !run_i || tick_o) begin
        cyc_q <= '0;
      end else begin
        cyc_q <= cyc_q + PHASE_W'(1);
      end
    end
  end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_master_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              mdc_o,
  output logic              mdo_o,
  output logic              oe_o,
  output logic              sample_o,
  output logic              done_o,
  output logic              rd_done_o
);

  localparam int HDR_LEN = 4 + 2 * ADDR_W;
  localparam int TX_W    = HDR_LEN + 2 + DATA_W;
  localparam int MAX_A   = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
  localparam int MAX_LEN = (MAX_A > HDR_LEN) ? MAX_A : HDR_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN);

  logic              busy_q, rd_q;
  seg_e              seg_q;
  phase_e            ph_q;
  logic [CNT_W-1:0]  bit_q;
  logic [TX_W-1:0]   tx_q;
  logic              mdc_q, mdo_q, oe_q, done_q;

  logic              n_busy, n_rd, fin;
  seg_e              n_seg;
  phase_e            n_ph;
  logic [CNT_W-1:0]  n_bit;
  logic [TX_W-1:0]   n_tx;
  logic [CNT_W-1:0]  seg_last;
  logic              n_drive, n_mdc, n_mdo;

  assign accept_o = start_i && !busy_q;

  // Index of the last bit in the current segment.
  always_comb begin
    case (seg_q)
      SEG_PRE:  seg_last = CNT_W'(PRE_LEN - 1);
      SEG_HDR:  seg_last = CNT_W'(HDR_LEN - 1);
      SEG_TURN: seg_last = rd_q ? '0 : CNT_W'(1);
      SEG_DATA: seg_last = CNT_W'(DATA_W - 1);
      default:  seg_last = '0;
    endcase
  end

  always_comb begin
    n_busy = busy_q;
    n_rd   = rd_q;
    n_seg  = seg_q;
    n_ph   = ph_q;
    n_bit  = bit_q;
    n_tx   = tx_q;
    fin    = 1'b0;
    if (accept_o) begin
      n_busy = 1'b1;
      n_rd   = rd_i;
      n_seg  = SEG_PRE;
      n_ph   = PH_LO0;
      n_bit  = '0;
      n_tx   = {SOF_CODE, (rd_i ? OP_RD : OP_WR), phy_i, reg_i, TURN_WR, wdata_i};
    end else if (busy_q && tick_i) begin
      if (ph_q != PH_LO1) begin
        n_ph = phase_e'(ph_q + 2'd1);
      end else begin
        n_ph = PH_LO0;
        if (seg_q != SEG_PRE) begin
          n_tx = {tx_q[TX_W-2:0], 1'b0};
        end
        if (bit_q == seg_last) begin
          n_bit = '0;
          case (seg_q)
            SEG_PRE:  n_seg = SEG_HDR;
            SEG_HDR:  n_seg = SEG_TURN;
            SEG_TURN: n_seg = SEG_DATA;
            SEG_DATA: n_seg = SEG_TAIL;
            default: begin
              n_busy = 1'b0;
              fin    = 1'b1;
            end
          endcase
        end else begin
          n_bit = bit_q + CNT_W'(1);
        end
      end
    end
  end

  // Line levels for the next cycle, registered below.
  always_comb begin
    n_drive = n_busy && ((n_seg == SEG_PRE) || (n_seg == SEG_HDR) ||
              (!n_rd && ((n_seg == SEG_TURN) || (n_seg == SEG_DATA))));
    n_mdc   = n_busy && ((n_ph == PH_HI0) || (n_ph == PH_HI1));
    n_mdo   = n_drive && ((n_seg == SEG_PRE) || n_tx[TX_W-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      seg_q  <= SEG_PRE;
      ph_q   <= PH_LO0;
      bit_q  <= '0;
      tx_q   <= '0;
      mdc_q  <= 1'b0;
      mdo_q  <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= n_busy;
      rd_q   <= n_rd;
      seg_q  <= n_seg;
      ph_q   <= n_ph;
      bit_q  <= n_bit;
      tx_q   <= n_tx;
      mdc_q  <= n_mdc;
      mdo_q  <= n_mdo;
      oe_q   <= n_drive;
      done_q <= fin;
    end
  end

  assign sample_o  = busy_q && tick_i && rd_q && (ph_q == PH_HI0) && (seg_q == SEG_DATA);
  assign rd_done_o = fin && rd_q;
  assign busy_o    = busy_q;
  assign mdc_o     = mdc_q;
  assign mdo_o     = mdo_q;
  assign oe_o      = oe_q;
  assign done_o    = done_q;

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_i,
  input  logic              mdi_i,
  input  logic              capture_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
      rd_q <= '0;
    end else begin
      if (sample_i) begin
        sr_q <= {sr_q[DATA_W-2:0], mdi_i};
      end
      if (capture_i) begin
        rd_q <= sr_q;
      end
    end
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int PHASE_W = 8,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  phy_addr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [PHASE_W-1:0] phase_len_i,
  input  logic               mdio_i,
  output logic               mdc_o,
  output logic               mdio_o,
  output logic               mdio_oe_o,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               busy_o,
  output logic               done_o
);

  logic accept, tick, sample, rd_done;

  mdio_phase_timer #(
    .PHASE_W (PHASE_W)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .len_i  (phase_len_i),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  mdio_frame_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .PRE_LEN (PRE_LEN)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .rd_i      (rd_i),
    .phy_i     (phy_addr_i),
    .reg_i     (reg_addr_i),
    .wdata_i   (wdata_i),
    .tick_i    (tick),
    .accept_o  (accept),
    .busy_o    (busy_o),
    .mdc_o     (mdc_o),
    .mdo_o     (mdio_o),
    .oe_o      (mdio_oe_o),
    .sample_o  (sample),
    .done_o    (done_o),
    .rd_done_o (rd_done)
  );

  mdio_rx_shift #(
    .DATA_W (DATA_W)
  ) rx_i (
    .clk       (clk),
    .rst       (rst),
    .sample_i  (sample),
    .mdi_i     (mdio_i),
    .capture_i (rd_done),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic mdc_o,
  input logic mdio_o,
  input logic mdio_oe_o,
  input logic busy_o,
  input logic done_o
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!mdc_o && !mdio_oe_o)); // R1

  AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o))); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o))); // R8

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)); // R8

endmodule

bind mdio_frame_master mdio_frame_master_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/mdio_frame_master_tb_top.sv
`timescale 1ns/1ps
module mdio_frame_master_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [4:0]  phy_addr_i = '0;
  logic [4:0]  reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [7:0]  phase_len_i = 8'd1;
  logic        mdio_i;
  logic        mdc_o, mdio_o, mdio_oe_o, busy_o, done_o;
  logic [15:0] rd_data_o;

  always #5 clk = ~clk;

  mdio_frame_master dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .phase_len_i(phase_len_i), .mdio_i(mdio_i), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .rd_data_o(rd_data_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_vec = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Device model: one read bit per falling MDC edge.
  int          fall_cnt = 0, base_fall = 0;
  int          rise_cnt = 0, base_rise = 0;
  int          stab_err = 0;
  logic [15:0] phy_word = '0;
  logic        cap_oe [128];
  logic        cap_v  [128];
  logic        exp_oe [128];
  logic        exp_v  [128];

  assign mdio_i = ((fall_cnt - base_fall) >= 47 && (fall_cnt - base_fall) < 63) ?
                  phy_word[62 - (fall_cnt - base_fall)] : 1'b1;

  always @(negedge mdc_o) begin
    int j;
    j = rise_cnt - base_rise - 1;
    if (j >= 0 && j < 128) begin
      if (mdio_o !== cap_v[j] || mdio_oe_o !== cap_oe[j]) stab_err++;
    end
    fall_cnt++;
  end

  always @(posedge mdc_o) begin
    int j;
    j = rise_cnt - base_rise;
    if (j >= 0 && j < 128) begin
      cap_oe[j] = mdio_oe_o;
      cap_v[j]  = mdio_o;
    end
    rise_cnt++;
  end

  function automatic string region(input bit rd, input int b);
    if (b < 32) return "R2 preamble";
    if (b < 46) return "R3 header";
    if (rd) return (b < 63) ? "R6 read turn/data" : "R7 tail";
    return (b < 64) ? "R5 write turn/data" : "R7 tail";
  endfunction

  task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] rp,
                         input logic [7:0] len, input bit poke);
    int nb, leff, exp_cyc, cnt, st0;
    logic [13:0] hdr;
    logic [15:0] prev_rd;
    nb = 0;
    for (int i = 0; i < 32; i++) begin exp_oe[nb] = 1; exp_v[nb] = 1; nb++; end
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    for (int i = 13; i >= 0; i--) begin exp_oe[nb] = 1; exp_v[nb] = hdr[i]; nb++; end
    if (rd) begin
      for (int i = 0; i < 17; i++) begin exp_oe[nb] = 0; exp_v[nb] = 0; nb++; end
    end else begin
      exp_oe[nb] = 1; exp_v[nb] = 1; nb++;
      exp_oe[nb] = 1; exp_v[nb] = 0; nb++;
      for (int i = 15; i >= 0; i--) begin exp_oe[nb] = 1; exp_v[nb] = wd[i]; nb++; end
    end
    exp_oe[nb] = 0; exp_v[nb] = 0; nb++;
    leff = (len == 0) ? 1 : int'(len);
    exp_cyc = 4 * nb * leff;

    @(negedge clk);
    prev_rd = rd_data_o;
    rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd; phase_len_i = len;
    phy_word = rp; base_fall = fall_cnt; base_rise = rise_cnt; st0 = stab_err;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R8 busy after start", longint'(busy_o), 1);
    // R10: scramble the request inputs during the frame
    rd_i = ~rd; phy_addr_i = 5'($urandom); reg_addr_i = 5'($urandom);
    wdata_i = 16'($urandom); phase_len_i = 8'($urandom_range(1, 9));
    cnt = 0;
    while (done_o !== 1'b1 && cnt < exp_cyc + 100) begin
      @(negedge clk);
      cnt++;
      start_i = poke && (cnt == exp_cyc / 2 || cnt == exp_cyc - 3); // R9
    end
    start_i = 1'b0;
    check(cnt == exp_cyc, "R4 frame length in cycles", cnt, exp_cyc);
    check(busy_o === 1'b0, "R8 busy low with done", longint'(busy_o), 0);
    check(rise_cnt - base_rise == nb, "R4 bit periods", rise_cnt - base_rise, nb);
    check(stab_err == st0, "R4 line stable in bit", stab_err - st0, 0);
    for (int b = 0; b < nb; b++) begin
      check(cap_oe[b] === exp_oe[b], {region(rd, b), " oe"}, longint'(cap_oe[b]), longint'(exp_oe[b]));
      if (exp_oe[b]) check(cap_v[b] === exp_v[b], {region(rd, b), " value"}, longint'(cap_v[b]), longint'(exp_v[b]));
    end
    if (rd) check(rd_data_o === rp, "R6 read data", rd_data_o, rp);
    else    check(rd_data_o === prev_rd, "R8 write keeps read data", rd_data_o, prev_rd);
    @(negedge clk);
    check(done_o === 1'b0, "R8 done single cycle", longint'(done_o), 0);
    check(mdc_o === 1'b0 && mdio_oe_o === 1'b0 && busy_o === 1'b0, "R1 idle after frame",
          {mdc_o, mdio_oe_o, busy_o}, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5E_ED01));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(mdc_o === 1'b0 && mdio_oe_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0,
          "R1 reset state", {mdc_o, mdio_oe_o, busy_o, done_o}, 0);

    // Directed corner cases
    run_txn(1'b0, 5'h00, 5'h00, 16'hFFFF, 16'h0000, 8'd0, 1'b0); // R4 zero length
    run_txn(1'b1, 5'h1F, 5'h1F, 16'h0000, 16'h8001, 8'd1, 1'b0); // R6 end bits
    run_txn(1'b0, 5'h15, 5'h0A, 16'hA5C3, 16'h1234, 8'd2, 1'b0); // R5 alternating
    run_txn(1'b1, 5'h01, 5'h10, 16'h0000, 16'h5AA5, 8'd7, 1'b1); // R9 R10
    run_txn(1'b0, 5'h0E, 5'h11, 16'h0001, 16'hFFFF, 8'd3, 1'b1); // R9 write
    run_txn(1'b1, 5'h02, 5'h03, 16'h0000, 16'h0000, 8'd1, 1'b0); // R6 all zero

    // Constrained random
    for (int t = 0; t < 24; t++) begin
      run_txn(1'($urandom), 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
              8'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule